// File: doc/BRIEF.md
# Horizontal Line Timer

This block is the horizontal half of a CRT timing controller. It counts character slots across a scan line, from zero up to a programmed total, and then starts the next line. From that count it derives four things: the horizontal display window, the horizontal sync pulse, a strobe marking the last character of the line, and a strobe at the middle of the line. The vertical logic uses the last-character strobe to advance its own counters. The mid-line strobe places a sync in the middle of a line when the display is interlaced.

All state advances only on cycles where `char_en` is high, so the block runs at the character rate from a faster clock. The `VARIANT` parameter (0 to 4) selects among five known controller behaviours. These behaviours differ in three ways: what a sync width of zero means, whether the display window can be skewed, and whether the sync output carries an extra pipeline delay. They also differ in how the line ends when the displayed count is larger than the total.

The register inputs are expected to be written while `rst_n` is low. They are then held steady while the block runs.

Top module: `hline_timer`

The block has two state machines. The sync pulse machine has two states. In HS_IDLE no pulse is running. It moves to HS_ACTIVE (transition "launch") when the count equals the sync position and the effective width is greater than one. In HS_ACTIVE a count of remaining characters steps down on each character. The machine returns to HS_IDLE (transition "expire") on the character whose remaining count is one. A pulse of width one is produced from HS_IDLE alone and never enters HS_ACTIVE. The display window has no state machine. It is a raw window followed by a two-stage skew pipeline.

## Requirements
- R1: `hcount` is 0 in reset. On each `char_en` cycle it advances by one, and it becomes 0 after the character where it equals `reg_total`. It holds its value whenever `char_en` is low.
- R2: `line_end` is high exactly while `hcount` equals `reg_total`.
- R3: `half_line` is high exactly while `hcount` equals `reg_total` shifted right by one bit.
- R4: With `reg_skew`=0, `disp_en` is high for characters whose count is below `reg_disp` and low for the others.
- R5: When `reg_disp` is greater than `reg_total`, variants 0 and 2 force `disp_en` low on the character where `hcount` equals `reg_total`. Variants 1, 3 and 4 leave every character of the line displayed.
- R6: On variants 0, 3 and 4, the `reg_skew` field changes `disp_en` as follows: 0 passes the raw window; 1 delays it by one character; 2 delays it by two characters; 3 holds `disp_en` low. On variants 1 and 2 the field is ignored and behaves as 0.
- R7: The sync pulse starts on the character where `hcount` equals `reg_sync_pos` and stays high for `reg_sync_width` characters. This holds for `hsync` directly on variants 0, 1 and 2.
- R8: A `reg_sync_width` of 0 produces no pulse on variants 0 and 1. On variants 2, 3 and 4 it produces a 16-character pulse.
- R9: A pulse that is still running when the line wraps continues into the next line until its width is used up.
- R10: On variants 3 and 4, `hsync` follows the pulse of R7 two characters later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_en | input | 1 | Character slot enable; all state advances only when high |
| reg_total | input | CW | Last character index of the line (line length minus one) |
| reg_disp | input | CW | Number of displayed characters per line |
| reg_sync_pos | input | CW | Character index where the sync pulse starts |
| reg_sync_width | input | WW | Sync pulse width in characters |
| reg_skew | input | 2 | Display skew: 0 none, 1 one char, 2 two chars, 3 off |
| hcount | output | CW | Current character count |
| disp_en | output | 1 | Horizontal display enable after skew |
| hsync | output | 1 | Horizontal sync pulse |
| line_end | output | 1 | High on the last character of the line |
| half_line | output | 1 | High on the middle character of the line |

## Verification
The assertions assume that the register fields change only while reset is held. Under that assumption the count never passes the total, and a skewed window always compares against a stable skew setting. The bench keeps to this rule: every scenario loads its fields under reset and then lets at least two full lines pass before it starts checking. This fills the skew and sync delay pipelines. The chosen sync widths and positions keep every pulse shorter than a line, so a pulse never meets its own start position while it is still running.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

    typedef enum logic {
        HS_IDLE   = 1'b0,
        HS_ACTIVE = 1'b1
    } hs_state_e;

    function automatic bit skew_supported(input int variant);
        return (variant == 0) || (variant == 3) || (variant == 4);
    endfunction

    function automatic bit border_on_overrun(input int variant);
        return (variant == 0) || (variant == 2);
    endfunction

    function automatic bit zero_width_is_full(input int variant);
        return variant >= 2;
    endfunction

    function automatic int sync_delay(input int variant);
        return ((variant == 3) || (variant == 4)) ? 2 : 0;
    endfunction

endpackage

// File: rtl/hlt_counter.sv
module hlt_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_en,
    input  logic [CW-1:0] reg_total,
    output logic [CW-1:0] hcount,
    output logic          line_end,
    output logic          half_line
);

    logic at_total;

    assign at_total  = (hcount == reg_total);
    assign line_end  = at_total;
    assign half_line = (hcount == (reg_total >> 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcount <= '0;
        end else if (char_en) begin
            hcount <= at_total ? '0 : hcount + 1'b1;
        end
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && hcount == reg_total) |=> (hcount == '0));

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !char_en |=> $stable(hcount));

    assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hcount <= reg_total);

endmodule

// File: rtl/hlt_display.sv
module hlt_display
    import hlt_pkg::*;
#(
    parameter int CW      = 8,
    parameter int VARIANT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_en,
    input  logic [CW-1:0] hcount,
    input  logic [CW-1:0] reg_total,
    input  logic [CW-1:0] reg_disp,
    input  logic [1:0]    reg_skew,
    output logic          disp_en
);

    localparam bit SKEW_ON = skew_supported(VARIANT);
    localparam bit BORDER  = border_on_overrun(VARIANT);

    logic       raw_en;
    logic       border_hit;
    logic [1:0] skew_eff;
    logic [1:0] dly;

    generate
        if (BORDER) begin : g_border
            assign border_hit = (reg_disp > reg_total) && (hcount == reg_total);
        end else begin : g_no_border
            assign border_hit = 1'b0;
        end
        if (SKEW_ON) begin : g_skew
            assign skew_eff = reg_skew;
        end else begin : g_no_skew
            assign skew_eff = 2'd0;
        end
    endgenerate

    assign raw_en = (hcount < reg_disp) && !border_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly <= '0;
        end else if (char_en) begin
            dly <= {dly[0], raw_en};
        end
    end

    always_comb begin
        unique case (skew_eff)
            2'd0:    disp_en = raw_en;
            2'd1:    disp_en = dly[0];
            2'd2:    disp_en = dly[1];
            default: disp_en = 1'b0;
        endcase
    end

    assert_skew1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        char_en |=> (skew_eff != 2'd1 || disp_en == $past(raw_en)));

    assert_suppress_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (SKEW_ON && reg_skew == 2'd3) |-> !disp_en);

endmodule

// File: rtl/hlt_hsync.sv
module hlt_hsync
    import hlt_pkg::*;
#(
    parameter int CW      = 8,
    parameter int WW      = 4,
    parameter int VARIANT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_en,
    input  logic [CW-1:0] hcount,
    input  logic [CW-1:0] reg_sync_pos,
    input  logic [WW-1:0] reg_sync_width,
    output logic          hsync
);

    localparam int  DELAY    = sync_delay(VARIANT);
    localparam bit  ZERO_MAX = zero_width_is_full(VARIANT);

    hs_state_e     state, state_n;
    logic [WW:0]   rem, rem_n;
    logic [WW:0]   width_eff;
    logic          start;
    logic          hs_core;

    always_comb begin
        if (reg_sync_width != '0) begin
            width_eff = {1'b0, reg_sync_width};
        end else if (ZERO_MAX) begin
            width_eff = {1'b1, {WW{1'b0}}};
        end else begin
            width_eff = '0;
        end
    end

    assign start = (hcount == reg_sync_pos) && (width_eff != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            rem   <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
        end
    end

    always_comb begin
        state_n = state;
        rem_n   = rem;
        hs_core = 1'b0;
        unique case (state)
            HS_IDLE: begin
                hs_core = start;
                if (char_en && start && width_eff > 1) begin
                    state_n = HS_ACTIVE;
                    rem_n   = width_eff - 1'b1;
                end
            end
            HS_ACTIVE: begin
                hs_core = 1'b1;
                if (char_en) begin
                    if (rem == 1) begin
                        state_n = HS_IDLE;
                        rem_n   = '0;
                    end else begin
                        rem_n = rem - 1'b1;
                    end
                end
            end
        endcase
    end

    generate
        if (DELAY > 0) begin : g_delay
            logic [DELAY-1:0] pipe;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= '0;
                end else if (char_en) begin
                    pipe[0] <= hs_core;
                    for (int i = 1; i < DELAY; i++) begin
                        pipe[i] <= pipe[i-1];
                    end
                end
            end
            assign hsync = pipe[DELAY-1];
        end else begin : g_direct
            assign hsync = hs_core;
        end
    endgenerate

    assert_rem_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_ACTIVE) |-> (rem != '0));

    assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_ACTIVE && char_en && rem == 1) |=> (state == HS_IDLE));

    assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_IDLE && char_en && start && width_eff > 1) |=> (state == HS_ACTIVE));

endmodule

// File: rtl/hline_timer.sv
module hline_timer
    import hlt_pkg::*;
#(
    parameter int CW      = 8,
    parameter int WW      = 4,
    parameter int VARIANT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_en,
    input  logic [CW-1:0] reg_total,
    input  logic [CW-1:0] reg_disp,
    input  logic [CW-1:0] reg_sync_pos,
    input  logic [WW-1:0] reg_sync_width,
    input  logic [1:0]    reg_skew,
    output logic [CW-1:0] hcount,
    output logic          disp_en,
    output logic          hsync,
    output logic          line_end,
    output logic          half_line
);

    hlt_counter #(.CW(CW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_en   (char_en),
        .reg_total (reg_total),
        .hcount    (hcount),
        .line_end  (line_end),
        .half_line (half_line)
    );

    hlt_display #(.CW(CW), .VARIANT(VARIANT)) u_display (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_en   (char_en),
        .hcount    (hcount),
        .reg_total (reg_total),
        .reg_disp  (reg_disp),
        .reg_skew  (reg_skew),
        .disp_en   (disp_en)
    );

    hlt_hsync #(.CW(CW), .WW(WW), .VARIANT(VARIANT)) u_hsync (
        .clk            (clk),
        .rst_n          (rst_n),
        .char_en        (char_en),
        .hcount         (hcount),
        .reg_sync_pos   (reg_sync_pos),
        .reg_sync_width (reg_sync_width),
        .hsync          (hsync)
    );

    assert_line_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && char_en) |=> (hcount == '0));

endmodule

// File: tb/tb_hline_timer.sv
module tb_hline_timer;

    localparam int NV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_en = 1'b1;
    logic [7:0] reg_total = 8'd19;
    logic [7:0] reg_disp = 8'd12;
    logic [7:0] reg_sync_pos = 8'd5;
    logic [3:0] reg_sync_width = 4'd4;
    logic [1:0] reg_skew = 2'd0;

    logic [7:0] hc [NV];
    logic       de [NV];
    logic       hs [NV];
    logic       le [NV];
    logic       hl [NV];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    for (genvar gi = 0; gi < NV; gi++) begin : g_v
        hline_timer #(.CW(8), .WW(4), .VARIANT(gi)) dut (
            .clk            (clk),
            .rst_n          (rst_n),
            .char_en        (char_en),
            .reg_total      (reg_total),
            .reg_disp       (reg_disp),
            .reg_sync_pos   (reg_sync_pos),
            .reg_sync_width (reg_sync_width),
            .reg_skew       (reg_skew),
            .hcount         (hc[gi]),
            .disp_en        (de[gi]),
            .hsync          (hs[gi]),
            .line_end       (le[gi]),
            .half_line      (hl[gi])
        );
    end

    task automatic check(input string req, input int v, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s variant %0d at t=%0t: actual %0d expected %0d", req, v, $time, act, exp);
        end
    endtask

    function automatic int raw_win(int v, int h, int tot, int dsp);
        if ((v == 0 || v == 2) && dsp > tot && h == tot) return 0;
        return (h < dsp) ? 1 : 0;
    endfunction

    function automatic int exp_de(int v, int h, int tot, int dsp, int sk);
        int n = tot + 1;
        int k = (v == 0 || v == 3) ? sk : 0;
        if (k == 3) return 0;
        return raw_win(v, (h - k + n) % n, tot, dsp);
    endfunction

    function automatic int exp_hs(int v, int h, int tot, int pos, int w);
        int n = tot + 1;
        int we = (w == 0) ? ((v >= 2) ? 16 : 0) : w;
        int d  = (v == 3) ? 2 : 0;
        int rel = ((h - d - pos) % n + 2 * n) % n;
        return (rel < we) ? 1 : 0;
    endfunction

    task automatic load(input int tot, input int dsp, input int pos, input int w, input int sk);
        @(negedge clk);
        rst_n          = 1'b0;
        char_en        = 1'b1;
        reg_total      = 8'(tot);
        reg_disp       = 8'(dsp);
        reg_sync_pos   = 8'(pos);
        reg_sync_width = 4'(w);
        reg_skew       = 2'(sk);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * (tot + 1) + 3) @(negedge clk);
    endtask

    task automatic check_line(input string dreq, input string hreq);
        int tot = int'(reg_total);
        for (int c = 0; c <= tot; c++) begin
            for (int v = 0; v < NV; v++) begin
                int h = int'(hc[v]);
                check("R2", v, int'(le[v]), (h == tot) ? 1 : 0);
                check("R3", v, int'(hl[v]), (h == tot / 2) ? 1 : 0);
                check(dreq, v, int'(de[v]),
                      exp_de(v, h, tot, int'(reg_disp), int'(reg_skew)));
                check(hreq, v, int'(hs[v]),
                      exp_hs(v, h, tot, int'(reg_sync_pos), int'(reg_sync_width)));
            end
            begin
                int prev = int'(hc[0]);
                @(negedge clk);
                check("R1", 0, int'(hc[0]), (prev == tot) ? 0 : prev + 1);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_total = 8'd19; reg_disp = 8'd12; reg_sync_pos = 8'd5;
        reg_sync_width = 4'd4; reg_skew = 2'd0;
        repeat (3) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            check("R1", v, int'(hc[v]), 0);
            check("R7", v, int'(hs[v]), 0);
        end
    endtask

    task automatic t_basic();
        load(19, 12, 14, 4, 0);
        check_line("R4", "R7 R10");
    endtask

    task automatic t_skew();
        for (int sk = 1; sk <= 3; sk++) begin
            load(19, 12, 14, 4, sk);
            check_line("R6", "R7");
        end
    endtask

    task automatic t_border();
        load(19, 25, 14, 4, 0);
        check_line("R5", "R7");
    endtask

    task automatic t_wrap();
        load(19, 12, 17, 6, 0);
        check_line("R4", "R9 R10");
    endtask

    task automatic t_zero_width();
        load(19, 12, 2, 0, 0);
        check_line("R4", "R8");
    endtask

    task automatic t_stall();
        int held;
        load(19, 12, 14, 4, 0);
        char_en = 1'b0;
        @(negedge clk);
        held = int'(hc[0]);
        repeat (6) @(negedge clk);
        check("R1", 0, int'(hc[0]), held);
        char_en = 1'b1;
        @(negedge clk);
        check("R1", 0, int'(hc[0]), (held == 19) ? 0 : held + 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_skew();
        t_border();
        t_wrap();
        t_zero_width();
        t_stall();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule